// File: doc/BRIEF.md
# Parallel Port FIFO Service Request Logic

This block sits between the control register bits of a FIFO-backed parallel port and the system's interrupt and DMA fabric. It merges several interrupt causes into one interrupt line: a level cause taken from the peripheral acknowledge line, an error-edge cause in the extended-capability mode, a FIFO-threshold service cause and a DMA terminal-count cause. It also raises the DMA request while the FIFO can accept or supply data. The two service causes disable themselves by issuing a one-cycle write-back strobe that the register file uses to set the service-mask bit.

Edge-triggered causes produce a pulse of `PULSE_CYC` clock cycles, sized so that the pulse lasts at least 200 ns. A new trigger that arrives while a pulse is running reloads the pulse timer, so it is never lost. The FIFO is `FIFO_DEPTH` bytes deep, with a fill count `CNT_W` bits wide. The threshold is `SVC_THRESH` bytes, which is half the depth by default. All inputs are synchronous to `clk`. The reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `ppt_svc_irq_dma`

## Requirements
- R1: While `ack_ie_i`=1 and `ack_n_i`=0 are sampled at a clock edge, `irq_o` is high after that edge, in any mode. It falls one cycle after either condition is removed, provided no pulse is running.
- R2: In mode 3'b011 with `err_mask_i`=0, a 1-to-0 change of `fault_n_i` between two clock edges starts an interrupt pulse after the second edge.
- R3: In mode 3'b011 with `fault_n_i`=0, a 1-to-0 change of `err_mask_i` starts an interrupt pulse.
- R4: Fault and mask edges cause no interrupt in any mode other than 3'b011.
- R5: In the FIFO modes 3'b010, 3'b011 and 3'b110, the threshold service cause fires when all of these hold: `dma_en_i`=0, `svc_i`=0, `dir_in_i`=0 and the empty space (`FIFO_DEPTH` minus `fill_i`) is at least `SVC_THRESH`. In the same cycle `svc_set_o` is high, and an interrupt pulse follows.
- R6: In a FIFO mode with `dma_en_i`=0, `svc_i`=0 and `dir_in_i`=1, the threshold service cause fires when `fill_i` is at least `SVC_THRESH`.
- R7: When the threshold is not met, or when `svc_i`=1, no `svc_set_o` is produced.
- R8: In a FIFO mode with `dma_en_i`=1 and `svc_i`=0, `tc_i`=1 together with `dack_n_i`=0 produces `svc_set_o` in the same cycle and an interrupt pulse. `drq_o` is low after that edge.
- R9: One cycle after it is sampled, `drq_o` equals `dma_en_i` AND NOT `svc_i` AND (the output direction with the FIFO not full, OR the input direction with the FIFO not empty, OR mode 3'b110). This holds only in the FIFO modes.
- R10: An interrupt pulse keeps `irq_o` high for exactly `PULSE_CYC` cycles after its trigger edge. A retrigger restarts the full count.
- R11: While reset is asserted, `irq_o`, `drq_o` and `svc_set_o` are all low.
- R12: Outside the FIFO modes (for example 3'b000 and 3'b100), neither `svc_set_o` nor `drq_o` is ever asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Port operating mode |
| dir_in_i | input | 1 | Transfer direction, 1 = peripheral to host |
| ack_ie_i | input | 1 | Acknowledge interrupt enable |
| ack_n_i | input | 1 | Peripheral acknowledge, active low |
| fault_n_i | input | 1 | Peripheral fault, active low |
| err_mask_i | input | 1 | Error interrupt mask, 0 = enabled |
| svc_i | input | 1 | Service-mask bit, 1 = service requests blocked |
| dma_en_i | input | 1 | DMA enable |
| fifo_full_i | input | 1 | FIFO full flag |
| fifo_empty_i | input | 1 | FIFO empty flag |
| fill_i | input | CNT_W | FIFO fill count |
| dack_n_i | input | 1 | DMA acknowledge, active low |
| tc_i | input | 1 | DMA terminal count |
| irq_o | output | 1 | Merged interrupt line |
| drq_o | output | 1 | DMA request |
| svc_set_o | output | 1 | One-cycle strobe that sets the service-mask bit |

## Verification
A vector table exercises the service and DMA decision across every FIFO mode, both directions and both DMA settings. Fill counts placed on either side of the threshold in each direction separate a correct empty-space calculation from a fill-count or off-by-one error. Full and empty flags, the test mode override and terminal count with and without acknowledge separate the three request terms from the terminal-count drop. Directed runs then measure pulse lengths for each error edge type and for a mid-pulse retrigger, which tells stretching apart from restarting. They also check that error edges in a non-error mode stay silent and that the acknowledge level follows its inputs.

// File: rtl/ppt_svc_pkg.sv
package ppt_svc_pkg;

  typedef enum logic [2:0] {
    PM_COMPAT = 3'b000,
    PM_BYTE   = 3'b001,
    PM_FIFO   = 3'b010,
    PM_ECP    = 3'b011,
    PM_EPP    = 3'b100,
    PM_RSVD   = 3'b101,
    PM_TEST   = 3'b110,
    PM_CONFIG = 3'b111
  } ppt_mode_e;

  typedef struct packed {
    logic fifo;
    logic ecp;
    logic test;
  } mode_dec_t;

  function automatic mode_dec_t decode_mode(input logic [2:0] m);
    mode_dec_t d;
    d.ecp  = (m == PM_ECP);
    d.test = (m == PM_TEST);
    d.fifo = (m == PM_FIFO) || d.ecp || d.test;
    return d;
  endfunction

endpackage

// File: rtl/ppt_err_edge.sv
module ppt_err_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic enable_i,
  input  logic fault_n_i,
  input  logic mask_i,
  output logic fire_o
);

  logic fault_q, fault_d;
  logic mask_q, mask_d;
  logic primed_q, primed_d;
  logic both_low;

  always_comb begin
    fault_d  = fault_n_i;
    mask_d   = mask_i;
    primed_d = 1'b1;
    both_low = !fault_n_i && !mask_i;
    // fires when fault and mask are now both low but were not both low before
    fire_o   = primed_q && enable_i && both_low && (fault_q || mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q  <= 1'b1;
      mask_q   <= 1'b1;
      primed_q <= 1'b0;
    end else begin
      fault_q  <= fault_d;
      mask_q   <= mask_d;
      primed_q <= primed_d;
    end
  end

endmodule

// File: rtl/ppt_svc_req.sv
module ppt_svc_req
  import ppt_svc_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = $clog2(FIFO_DEPTH) + 1,
  parameter int SVC_THRESH = FIFO_DEPTH / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mode_dec_t        mode_dec_i,
  input  logic             dir_in_i,
  input  logic             svc_i,
  input  logic             dma_en_i,
  input  logic             fifo_full_i,
  input  logic             fifo_empty_i,
  input  logic [CNT_W-1:0] fill_i,
  input  logic             dack_n_i,
  input  logic             tc_i,
  output logic             thr_fire_o,
  output logic             tc_fire_o,
  output logic             drq_o
);

  // empty space >= threshold  <=>  fill <= depth - threshold
  localparam logic [CNT_W-1:0] OUT_FILL_MAX = CNT_W'(FIFO_DEPTH - SVC_THRESH);
  localparam logic [CNT_W-1:0] IN_FILL_MIN  = CNT_W'(SVC_THRESH);

  logic armed;
  logic out_ok, in_ok;
  logic drq_cond;
  logic drq_q, drq_d;

  always_comb begin
    armed      = mode_dec_i.fifo && !svc_i;
    out_ok     = !dir_in_i && (fill_i <= OUT_FILL_MAX);
    in_ok      = dir_in_i && (fill_i >= IN_FILL_MIN);
    thr_fire_o = armed && !dma_en_i && (out_ok || in_ok);
    tc_fire_o  = armed && dma_en_i && tc_i && !dack_n_i;
    drq_cond   = armed && dma_en_i &&
                 ((!dir_in_i && !fifo_full_i) ||
                  (dir_in_i && !fifo_empty_i) ||
                  mode_dec_i.test);
    drq_d      = drq_cond && !tc_fire_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drq_q <= 1'b0;
    else        drq_q <= drq_d;
  end

  assign drq_o = drq_q;

endmodule

// File: rtl/ppt_irq_stretch.sv
module ppt_irq_stretch #(
  parameter int PULSE_CYC = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  input  logic level_i,
  output logic irq_o
);

  localparam int PW_W = $clog2(PULSE_CYC + 1);
  localparam logic [PW_W-1:0] PW_LOAD = PW_W'(PULSE_CYC);

  logic [PW_W-1:0] cnt_q, cnt_d;
  logic            lvl_q, lvl_d;
  logic            cnt_en;

  always_comb begin
    cnt_en = trig_i || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (trig_i)          cnt_d = PW_LOAD;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    lvl_d  = level_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign irq_o = lvl_q || (cnt_q != '0);

endmodule

// File: rtl/ppt_svc_irq_dma.sv
module ppt_svc_irq_dma
  import ppt_svc_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = $clog2(FIFO_DEPTH) + 1,
  parameter int SVC_THRESH = FIFO_DEPTH / 2,
  parameter int PULSE_CYC  = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode_i,
  input  logic             dir_in_i,
  input  logic             ack_ie_i,
  input  logic             ack_n_i,
  input  logic             fault_n_i,
  input  logic             err_mask_i,
  input  logic             svc_i,
  input  logic             dma_en_i,
  input  logic             fifo_full_i,
  input  logic             fifo_empty_i,
  input  logic [CNT_W-1:0] fill_i,
  input  logic             dack_n_i,
  input  logic             tc_i,
  output logic             irq_o,
  output logic             drq_o,
  output logic             svc_set_o
);

  logic      rs_meta_q, rst_sync_n;
  mode_dec_t mdec;
  logic      err_fire, thr_fire, tc_fire;
  logic      ack_lvl, any_trig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q  <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rs_meta_q  <= 1'b1;
      rst_sync_n <= rs_meta_q;
    end
  end

  always_comb begin
    mdec     = decode_mode(mode_i);
    ack_lvl  = ack_ie_i && !ack_n_i;
    any_trig = err_fire || thr_fire || tc_fire;
  end

  ppt_err_edge u_err (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .enable_i  (mdec.ecp),
    .fault_n_i (fault_n_i),
    .mask_i    (err_mask_i),
    .fire_o    (err_fire)
  );

  ppt_svc_req #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .CNT_W      (CNT_W),
    .SVC_THRESH (SVC_THRESH)
  ) u_req (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .mode_dec_i   (mdec),
    .dir_in_i     (dir_in_i),
    .svc_i        (svc_i),
    .dma_en_i     (dma_en_i),
    .fifo_full_i  (fifo_full_i),
    .fifo_empty_i (fifo_empty_i),
    .fill_i       (fill_i),
    .dack_n_i     (dack_n_i),
    .tc_i         (tc_i),
    .thr_fire_o   (thr_fire),
    .tc_fire_o    (tc_fire),
    .drq_o        (drq_o)
  );

  ppt_irq_stretch #(
    .PULSE_CYC (PULSE_CYC)
  ) u_pulse (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .trig_i  (any_trig),
    .level_i (ack_lvl),
    .irq_o   (irq_o)
  );

  assign svc_set_o = rst_sync_n && (thr_fire || tc_fire);

endmodule

// File: rtl/ppt_svc_irq_dma_chk.sv
module ppt_svc_irq_dma_chk (
  input logic       clk,
  input logic       rst_ok,
  input logic [2:0] mode_i,
  input logic       ack_ie_i,
  input logic       ack_n_i,
  input logic       svc_i,
  input logic       dma_en_i,
  input logic       dack_n_i,
  input logic       tc_i,
  input logic       irq_o,
  input logic       drq_o,
  input logic       svc_set_o
);

  logic ok_q;
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) ok_q <= 1'b0;
    else         ok_q <= 1'b1;
  end

  // R11: all outputs quiet while held in reset
  always @(negedge clk) begin
    if (!rst_ok) begin
      a_r11_reset_quiet: assert (!irq_o && !drq_o && !svc_set_o)
        else $error("R11 output active during reset");
    end
  end

  a_r1_ack_level: assert property (@(posedge clk) disable iff (!ok_q)
    $past(ack_ie_i && !ack_n_i) |-> irq_o);

  a_r9_drq_needs_enable: assert property (@(posedge clk) disable iff (!ok_q)
    drq_o |-> $past(dma_en_i && !svc_i));

  a_r8_tc_drops_drq: assert property (@(posedge clk) disable iff (!rst_ok)
    (svc_set_o && tc_i && !dack_n_i) |=> !drq_o);

  a_r5_set_raises_irq: assert property (@(posedge clk) disable iff (!rst_ok)
    svc_set_o |=> irq_o);

  a_r7_blocked_by_svc: assert property (@(posedge clk) disable iff (!rst_ok)
    svc_i |-> !svc_set_o);

  a_r12_fifo_modes_only: assert property (@(posedge clk) disable iff (!rst_ok)
    svc_set_o |-> (mode_i == 3'b010 || mode_i == 3'b011 || mode_i == 3'b110));

endmodule

bind ppt_svc_irq_dma ppt_svc_irq_dma_chk u_chk (
  .clk       (clk),
  .rst_ok    (rst_sync_n),
  .mode_i    (mode_i),
  .ack_ie_i  (ack_ie_i),
  .ack_n_i   (ack_n_i),
  .svc_i     (svc_i),
  .dma_en_i  (dma_en_i),
  .dack_n_i  (dack_n_i),
  .tc_i      (tc_i),
  .irq_o     (irq_o),
  .drq_o     (drq_o),
  .svc_set_o (svc_set_o)
);

// File: tb/ppt_svc_irq_dma_tb.sv
`timescale 1ns/1ps
module ppt_svc_irq_dma_tb;

  localparam int P = 25;

  logic       clk;
  logic       rst_n;
  logic [2:0] mode_i;
  logic       dir_in_i, ack_ie_i, ack_n_i, fault_n_i, err_mask_i;
  logic       svc_i, dma_en_i, fifo_full_i, fifo_empty_i;
  logic [4:0] fill_i;
  logic       dack_n_i, tc_i;
  logic       irq_o, drq_o, svc_set_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  ppt_svc_irq_dma #(.PULSE_CYC(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .dir_in_i(dir_in_i),
    .ack_ie_i(ack_ie_i), .ack_n_i(ack_n_i), .fault_n_i(fault_n_i),
    .err_mask_i(err_mask_i), .svc_i(svc_i), .dma_en_i(dma_en_i),
    .fifo_full_i(fifo_full_i), .fifo_empty_i(fifo_empty_i), .fill_i(fill_i),
    .dack_n_i(dack_n_i), .tc_i(tc_i), .irq_o(irq_o), .drq_o(drq_o),
    .svc_set_o(svc_set_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // fields: mode[16:14] dir[13] dma[12] svc[11] full[10] empty[9]
  //         fill[8:4] dack_n[3] tc[2] exp_set[1] exp_drq[0]
  localparam logic [16:0] VEC [18] = '{
    {3'b010,1'b0,1'b0,1'b0,1'b0,1'b1,5'd0, 1'b1,1'b0,1'b1,1'b0},
    {3'b010,1'b0,1'b0,1'b0,1'b0,1'b0,5'd8, 1'b1,1'b0,1'b1,1'b0},
    {3'b010,1'b0,1'b0,1'b0,1'b0,1'b0,5'd9, 1'b1,1'b0,1'b0,1'b0},
    {3'b011,1'b1,1'b0,1'b0,1'b0,1'b0,5'd8, 1'b1,1'b0,1'b1,1'b0},
    {3'b011,1'b1,1'b0,1'b0,1'b0,1'b0,5'd7, 1'b1,1'b0,1'b0,1'b0},
    {3'b110,1'b1,1'b0,1'b0,1'b1,1'b0,5'd16,1'b1,1'b0,1'b1,1'b0},
    {3'b010,1'b0,1'b0,1'b1,1'b0,1'b1,5'd0, 1'b1,1'b0,1'b0,1'b0},
    {3'b010,1'b0,1'b1,1'b0,1'b0,1'b0,5'd3, 1'b1,1'b0,1'b0,1'b1},
    {3'b010,1'b0,1'b1,1'b0,1'b1,1'b0,5'd16,1'b1,1'b0,1'b0,1'b0},
    {3'b011,1'b1,1'b1,1'b0,1'b0,1'b0,5'd2, 1'b1,1'b0,1'b0,1'b1},
    {3'b011,1'b1,1'b1,1'b0,1'b0,1'b1,5'd0, 1'b1,1'b0,1'b0,1'b0},
    {3'b110,1'b0,1'b1,1'b0,1'b1,1'b0,5'd16,1'b1,1'b0,1'b0,1'b1},
    {3'b010,1'b0,1'b1,1'b1,1'b0,1'b0,5'd3, 1'b1,1'b0,1'b0,1'b0},
    {3'b000,1'b0,1'b1,1'b0,1'b0,1'b1,5'd0, 1'b1,1'b0,1'b0,1'b0},
    {3'b100,1'b1,1'b0,1'b0,1'b0,1'b0,5'd8, 1'b1,1'b0,1'b0,1'b0},
    {3'b010,1'b0,1'b1,1'b0,1'b0,1'b0,5'd3, 1'b0,1'b1,1'b1,1'b0},
    {3'b010,1'b0,1'b1,1'b0,1'b0,1'b0,5'd3, 1'b1,1'b1,1'b0,1'b1},
    {3'b011,1'b1,1'b0,1'b0,1'b0,1'b0,5'd7, 1'b0,1'b1,1'b0,1'b0}
  };

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic idle();
    mode_i = 3'b000; dir_in_i = 0; ack_ie_i = 0; ack_n_i = 1;
    fault_n_i = 1; err_mask_i = 1; svc_i = 1; dma_en_i = 0;
    fifo_full_i = 0; fifo_empty_i = 1; fill_i = 0; dack_n_i = 1; tc_i = 0;
  endtask

  task automatic count_irq(input int cycles, inout int cnt);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (irq_o) cnt++;
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int hi;
    idle();
    rst_n = 1'b0;
    svc_i = 1'b0; fill_i = 5'd0; mode_i = 3'b010; // would fire if not in reset
    repeat (3) @(negedge clk);
    chk("R11 irq in reset", irq_o, 0);
    chk("R11 drq in reset", drq_o, 0);
    chk("R11 svc_set in reset", svc_set_o, 0);
    idle();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table walk: R5 R6 R7 R8 R9 R12
    for (int v = 0; v < 18; v++) begin
      mode_i = VEC[v][16:14]; dir_in_i = VEC[v][13]; dma_en_i = VEC[v][12];
      svc_i = VEC[v][11]; fifo_full_i = VEC[v][10]; fifo_empty_i = VEC[v][9];
      fill_i = VEC[v][8:4]; dack_n_i = VEC[v][3]; tc_i = VEC[v][2];
      #1;
      chk($sformatf("R5/R6/R7/R8/R12 svc_set row %0d", v), svc_set_o, VEC[v][1]);
      @(negedge clk);
      chk($sformatf("R8/R9/R12 drq row %0d", v), drq_o, VEC[v][0]);
    end
    idle();
    repeat (P + 5) @(negedge clk);

    // R8: terminal count pulse length, service bit written back after strobe
    mode_i = 3'b010; dma_en_i = 1; svc_i = 0; fifo_empty_i = 0; fill_i = 5'd4;
    dack_n_i = 0; tc_i = 1;
    #1 chk("R8 tc strobe", svc_set_o, 1);
    hi = 0;
    @(negedge clk);
    chk("R8 drq after tc", drq_o, 0);
    if (irq_o) hi++;
    svc_i = 1; tc_i = 0; dack_n_i = 1;
    count_irq(40, hi);
    chk("R8/R10 tc pulse width", hi, P);
    idle();

    // R2: fault falls in ECP mode
    mode_i = 3'b011; err_mask_i = 0; fault_n_i = 1;
    repeat (2) @(negedge clk);
    fault_n_i = 0;
    hi = 0; count_irq(40, hi);
    chk("R2/R10 fault pulse width", hi, P);

    // R3: mask falls while fault low
    err_mask_i = 1;
    repeat (2) @(negedge clk);
    chk("R3 mask rise no irq", irq_o, 0);
    err_mask_i = 0;
    hi = 0; count_irq(40, hi);
    chk("R3/R10 mask pulse width", hi, P);

    // R10: retrigger restarts the count
    fault_n_i = 1;
    repeat (2) @(negedge clk);
    fault_n_i = 0;
    hi = 0; count_irq(10, hi);
    fault_n_i = 1;
    count_irq(1, hi);
    fault_n_i = 0;
    count_irq(60, hi);
    chk("R10 retrigger length", hi, 11 + P);

    // R4: error edges ignored outside ECP (FIFO mode, service blocked)
    idle();
    mode_i = 3'b010; err_mask_i = 0; fault_n_i = 1;
    repeat (2) @(negedge clk);
    fault_n_i = 0;
    hi = 0; count_irq(40, hi);
    chk("R4 fault edge in mode 010", hi, 0);
    idle();
    mode_i = 3'b000; fault_n_i = 0; err_mask_i = 1;
    repeat (2) @(negedge clk);
    err_mask_i = 0;
    hi = 0; count_irq(40, hi);
    chk("R4 mask edge in mode 000", hi, 0);

    // R1: acknowledge level interrupt
    idle();
    repeat (2) @(negedge clk);
    ack_ie_i = 1; ack_n_i = 0;
    @(negedge clk);
    chk("R1 ack level rises", irq_o, 1);
    repeat (3) @(negedge clk);
    chk("R1 ack level held", irq_o, 1);
    ack_n_i = 1;
    @(negedge clk);
    chk("R1 ack release", irq_o, 0);
    ack_ie_i = 0; ack_n_i = 0;
    @(negedge clk);
    chk("R1 ack disabled", irq_o, 0);

    done = 1;
    finish_run();
  end

endmodule